// File: doc/BRIEF.md
# Card Controller Status and Interrupt Unit

This block gathers the condition flags of a memory-card host controller into one 32-bit status word and turns that word into two interrupt lines. The low eleven bits latch single-cycle event pulses from the command and data engines. Each such bit stays set until software writes a one to its position in a dedicated clear register. Bits 21 to 11 show the present state of the transmit/receive FIFO and the command engine, and they follow their inputs cycle by cycle. Two mask registers each select which status bits raise their own interrupt line. A read-only window at the top of the register space returns eight identification bytes.

Software uses a simple word bus with a 12-bit byte offset. A cycle with `bus_sel` high and `bus_wr` high is a write. A cycle with `bus_sel` high and `bus_wr` low is a read, and its data appears on `bus_rdata` after that clock edge and stays there until the next read. The producers of the event pulses and of the live FIFO flags sit outside this block.

Top module: `sdstat_unit`

## Requirements
- R1: After reset the event bits, both mask registers, `bus_rdata` and both interrupt lines are zero.
- R2: A high `evt_pulse[i]` at a clock edge sets status bit i, and the bit holds after the pulse ends. Bit 9 is reserved: a pulse on it is ignored and the bit always reads 0.
- R3: A write to offset 0x038 clears exactly the event bits whose positions are one in bits [10:0] of the written data. Written bits 31:11 have no effect.
- R4: When an event pulse and a clear for the same bit meet at one clock edge, the bit ends up set.
- R5: Status bits 21:11 equal `live_state[10:0]` at all times, and a clear write does not change them. Bits 31:22 read as zero.
- R6: The mask for line 0 lives at offset 0x03C and the mask for line 1 at offset 0x040. Both are 32 bits wide, writable and readable.
- R7: `irq_out[k]` is high exactly when the status word ANDed with mask k was nonzero in the previous cycle. It is registered, so it changes one cycle after the status or mask changes.
- R8: A read at offset 0xFE0 + 4*n, with n from 0 to 7, returns identification byte n from the sequence 0x81, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in bits 7:0, and zero in the bits above.
- R9: A read of any offset other than status (0x034), the two masks or the ID window returns zero, and so does a read of the clear offset. A write to any offset other than clear or a mask changes no state, and this includes the status offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read when selected |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| evt_pulse | input | 11 | Event set pulses for status bits 10:0 |
| live_state | input | 11 | Live condition flags for status bits 21:11 |
| irq_out | output | 2 | Interrupt line per mask register |

## Verification
The checker assumes that `evt_pulse` and the bus signals change only away from the rising edge, and that an event pulse counts once for every edge at which it is seen high. For the mask property it also assumes that the bus offset is word-aligned. The bench drives every input on the falling edge and holds each pulse for one edge only. It aligns every offset it uses. It lines up event pulses with clear writes only when it tests set-over-clear priority on purpose.

// File: rtl/sdstat_pkg.sv
package sdstat_pkg;

  localparam int ADDR_W = 12;
  localparam logic [ADDR_W-1:0] OFF_STATUS = 12'h034;
  localparam logic [ADDR_W-1:0] OFF_CLEAR  = 12'h038;
  localparam logic [ADDR_W-1:0] OFF_MASK0  = 12'h03C;
  localparam logic [6:0]        ID_PAGE    = 7'h7F;

  // Identification byte n of the read-only window.
  function automatic logic [7:0] id_byte(input logic [2:0] idx);
    logic [7:0] b;
    case (idx)
      3'd0: b = 8'h81;
      3'd1: b = 8'h11;
      3'd2: b = 8'h04;
      3'd3: b = 8'h00;
      3'd4: b = 8'h0D;
      3'd5: b = 8'hF0;
      3'd6: b = 8'h05;
      default: b = 8'hB1;
    endcase
    return b;
  endfunction

  // Sticky update: clear first, then set, so a set always wins.
  function automatic logic [31:0] sticky_next(input logic [31:0] cur,
                                              input logic [31:0] set,
                                              input logic [31:0] clr,
                                              input logic [31:0] impl);
    return ((cur & ~clr) | set) & impl;
  endfunction

  // True when any masked status bit is set.
  function automatic logic masked_hit(input logic [31:0] stat,
                                      input logic [31:0] msk);
    return |(stat & msk);
  endfunction

endpackage

// File: rtl/sdstat_events.sv
module sdstat_events
  import sdstat_pkg::*;
#(
  parameter int          EVT_W = 11,
  parameter logic [31:0] IMPL  = 32'h0000_05FF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_W-1:0] set_i,
  input  logic             clr_stb_i,
  input  logic [EVT_W-1:0] clr_bits_i,
  output logic [EVT_W-1:0] evt_q
);

  logic [31:0] set_w, clr_w, cur_w, nxt_w;

  always_comb begin
    set_w = '0;
    clr_w = '0;
    cur_w = '0;
    set_w[EVT_W-1:0] = set_i;
    cur_w[EVT_W-1:0] = evt_q;
    if (clr_stb_i) clr_w[EVT_W-1:0] = clr_bits_i;
    nxt_w = sticky_next(cur_w, set_w, clr_w, IMPL);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) evt_q <= '0;
    else        evt_q <= nxt_w[EVT_W-1:0];
  end

endmodule

// File: rtl/sdstat_irq.sv
module sdstat_irq
  import sdstat_pkg::*;
#(
  parameter int NUM_IRQ = 2,
  parameter int DATA_W  = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_IRQ-1:0]             mask_wr_i,
  input  logic [DATA_W-1:0]              wdata_i,
  input  logic [DATA_W-1:0]              status_i,
  output logic [NUM_IRQ-1:0][DATA_W-1:0] mask_q,
  output logic [NUM_IRQ-1:0]             irq_q
);

  for (genvar k = 0; k < NUM_IRQ; k++) begin : g_line
    logic hit_w;

    always_ff @(posedge clk) begin
      if (!rst_n)            mask_q[k] <= '0;
      else if (mask_wr_i[k]) mask_q[k] <= wdata_i;
    end

    always_comb hit_w = masked_hit(32'(status_i), 32'(mask_q[k]));

    always_ff @(posedge clk) begin
      if (!rst_n) irq_q[k] <= 1'b0;
      else        irq_q[k] <= hit_w;
    end
  end

endmodule

// File: rtl/sdstat_regbus.sv
module sdstat_regbus
  import sdstat_pkg::*;
#(
  parameter int NUM_IRQ = 2,
  parameter int DATA_W  = 32,
  parameter int EVT_W   = 11
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           sel_i,
  input  logic                           wr_i,
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic [DATA_W-1:0]              wdata_i,
  input  logic [DATA_W-1:0]              status_i,
  input  logic [NUM_IRQ-1:0][DATA_W-1:0] mask_i,
  output logic                           clr_stb_o,
  output logic [EVT_W-1:0]               clr_bits_o,
  output logic [NUM_IRQ-1:0]             mask_wr_o,
  output logic [DATA_W-1:0]              rdata_q
);

  localparam int WA_W = ADDR_W - 2;

  logic [WA_W-1:0]    word_w;
  logic               wr_stb, rd_stb, hit_status, hit_id;
  logic [NUM_IRQ-1:0] hit_mask;
  logic [DATA_W-1:0]  rd_next;

  assign word_w     = addr_i[ADDR_W-1:2];
  assign wr_stb     = sel_i & wr_i;
  assign rd_stb     = sel_i & ~wr_i;
  assign hit_status = (word_w == OFF_STATUS[ADDR_W-1:2]);
  assign hit_id     = (addr_i[ADDR_W-1:5] == ID_PAGE);
  assign clr_stb_o  = wr_stb & (word_w == OFF_CLEAR[ADDR_W-1:2]);
  assign clr_bits_o = wdata_i[EVT_W-1:0];

  for (genvar k = 0; k < NUM_IRQ; k++) begin : g_dec
    localparam logic [ADDR_W-1:0] OFF_K = OFF_MASK0 + ADDR_W'(4 * k);
    assign hit_mask[k]  = (word_w == OFF_K[ADDR_W-1:2]);
    assign mask_wr_o[k] = wr_stb & hit_mask[k];
  end

  always_comb begin
    rd_next = '0;
    if (hit_status) rd_next = status_i;
    for (int k = 0; k < NUM_IRQ; k++)
      if (hit_mask[k]) rd_next = mask_i[k];
    if (hit_id) rd_next = DATA_W'(id_byte(addr_i[4:2]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      rdata_q <= '0;
    else if (rd_stb) rdata_q <= rd_next;
  end

endmodule

// File: rtl/sdstat_unit.sv
module sdstat_unit
  import sdstat_pkg::*;
#(
  parameter int          NUM_IRQ = 2,
  parameter int          DATA_W  = 32,
  parameter int          EVT_W   = 11,
  parameter int          LIVE_W  = 11,
  parameter logic [31:0] IMPL    = 32'h0000_05FF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [11:0]        bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [EVT_W-1:0]   evt_pulse,
  input  logic [LIVE_W-1:0]  live_state,
  output logic [NUM_IRQ-1:0] irq_out
);

  localparam int PAD_W = DATA_W - EVT_W - LIVE_W;

  logic [EVT_W-1:0]               evt_q;
  logic                           clr_stb;
  logic [EVT_W-1:0]               clr_bits;
  logic [NUM_IRQ-1:0]             mask_wr;
  logic [NUM_IRQ-1:0][DATA_W-1:0] mask_q;
  logic [DATA_W-1:0]              status_word;

  assign status_word = {{PAD_W{1'b0}}, live_state, evt_q};

  sdstat_regbus #(.NUM_IRQ(NUM_IRQ), .DATA_W(DATA_W), .EVT_W(EVT_W)) u_bus (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_i      (bus_sel),
    .wr_i       (bus_wr),
    .addr_i     (bus_addr),
    .wdata_i    (bus_wdata),
    .status_i   (status_word),
    .mask_i     (mask_q),
    .clr_stb_o  (clr_stb),
    .clr_bits_o (clr_bits),
    .mask_wr_o  (mask_wr),
    .rdata_q    (bus_rdata)
  );

  sdstat_events #(.EVT_W(EVT_W), .IMPL(IMPL)) u_evt (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_i      (evt_pulse),
    .clr_stb_i  (clr_stb),
    .clr_bits_i (clr_bits),
    .evt_q      (evt_q)
  );

  sdstat_irq #(.NUM_IRQ(NUM_IRQ), .DATA_W(DATA_W)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .mask_wr_i (mask_wr),
    .wdata_i   (bus_wdata),
    .status_i  (status_word),
    .mask_q    (mask_q),
    .irq_q     (irq_out)
  );

endmodule

// File: rtl/sdstat_unit_chk.sv
module sdstat_unit_chk
  import sdstat_pkg::*;
#(
  parameter int          NUM_IRQ = 2,
  parameter int          DATA_W  = 32,
  parameter int          EVT_W   = 11,
  parameter logic [31:0] IMPL    = 32'h0000_05FF
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           bus_sel,
  input logic                           bus_wr,
  input logic [11:0]                    bus_addr,
  input logic [DATA_W-1:0]              bus_wdata,
  input logic [EVT_W-1:0]               evt_pulse,
  input logic                           clr_stb,
  input logic [DATA_W-1:0]              status_word,
  input logic [NUM_IRQ-1:0][DATA_W-1:0] mask_q,
  input logic [NUM_IRQ-1:0]             irq_out
);

  localparam logic [EVT_W-1:0] IMPL_E = IMPL[EVT_W-1:0];

  AST_STICKY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evt_pulse & IMPL_E)) |=>
      ((status_word[EVT_W-1:0] & $past(evt_pulse & IMPL_E)) == $past(evt_pulse & IMPL_E))); // R2

  AST_NO_SPONT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_word[EVT_W-1:0] & ~$past(status_word[EVT_W-1:0])
               & ~$past(evt_pulse)) == '0)); // R2

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stb |=> ((status_word[EVT_W-1:0]
                  & $past(bus_wdata[EVT_W-1:0] & ~evt_pulse)) == '0)); // R3

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    status_word[DATA_W-1:22] == '0); // R5

  AST_MASK0_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == OFF_MASK0) |=> (mask_q[0] == $past(bus_wdata))); // R6

  for (genvar k = 0; k < NUM_IRQ; k++) begin : g_irq_chk
    AST_IRQ_LAG: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (irq_out[k] == $past(|(status_word & mask_q[k])))); // R7
  end

endmodule

bind sdstat_unit sdstat_unit_chk #(
  .NUM_IRQ(NUM_IRQ), .DATA_W(DATA_W), .EVT_W(EVT_W), .IMPL(IMPL)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_sel     (bus_sel),
  .bus_wr      (bus_wr),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .evt_pulse   (evt_pulse),
  .clr_stb     (clr_stb),
  .status_word (status_word),
  .mask_q      (mask_q),
  .irq_out     (irq_out)
);

// File: tb/sdstat_unit_tb.sv
module sdstat_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [10:0] evt_pulse = '0;
  logic [10:0] live_state = '0;
  logic [1:0]  irq_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sdstat_unit u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_pulse(evt_pulse), .live_state(live_state), .irq_out(irq_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(posedge clk);
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic pulse(input logic [10:0] v);
    @(negedge clk);
    evt_pulse = v;
    @(posedge clk);
    @(negedge clk);
    evt_pulse = '0;
  endtask

  function automatic logic [7:0] expect_id(input int n);
    logic [63:0] seq = 64'hB105_F00D_0004_1181;
    return seq[n*8 +: 8];
  endfunction

  task automatic t_reset();
    logic [31:0] r;
    check("R1 irq after reset", 32'(irq_out), 32'h0);
    check("R1 rdata after reset", bus_rdata, 32'h0);
    bus_read(12'h034, r); check("R1 status after reset", r, 32'h0);
    bus_read(12'h03C, r); check("R1 mask0 after reset", r, 32'h0);
    bus_read(12'h040, r); check("R1 mask1 after reset", r, 32'h0);
  endtask

  task automatic t_sticky();
    logic [31:0] r;
    pulse(11'h041);
    bus_read(12'h034, r); check("R2 sticky bits 0 and 6", r, 32'h41);
    pulse(11'h200);
    bus_read(12'h034, r); check("R2 reserved bit 9 ignored", r, 32'h41);
  endtask

  task automatic t_live();
    logic [31:0] r;
    @(negedge clk); live_state = 11'h5A5;
    bus_read(12'h034, r); check("R5 live bits mirror input", r, (32'h5A5 << 11) | 32'h41);
    bus_write(12'h038, 32'hFFFF_FFFF);
    bus_read(12'h034, r); check("R3 R5 clear all keeps live bits", r, 32'h5A5 << 11);
    @(negedge clk); live_state = '0;
  endtask

  task automatic t_partial();
    logic [31:0] r;
    pulse(11'h0FF);
    bus_write(12'h038, 32'hFFFF_F8F0);
    bus_read(12'h034, r); check("R3 partial clear", r, 32'h0F);
  endtask

  task automatic t_setwins();
    logic [31:0] r;
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 12'h038; bus_wdata = 32'h0F;
    evt_pulse = 11'h008;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; evt_pulse = '0;
    bus_read(12'h034, r); check("R4 set wins over clear", r, 32'h08);
    bus_write(12'h038, 32'h7FF);
    bus_read(12'h034, r); check("R3 clear back to zero", r, 32'h0);
  endtask

  task automatic t_mask();
    logic [31:0] r;
    bus_write(12'h03C, 32'hDEAD_BEEF);
    bus_write(12'h040, 32'h1234_5678);
    bus_read(12'h03C, r); check("R6 mask0 readback", r, 32'hDEAD_BEEF);
    bus_read(12'h040, r); check("R6 mask1 readback", r, 32'h1234_5678);
    bus_write(12'h03C, 32'h0);
    bus_write(12'h040, 32'h0);
  endtask

  task automatic t_irq();
    bus_write(12'h03C, 32'h80);
    bus_write(12'h040, 32'h1000);
    @(negedge clk); evt_pulse = 11'h080;
    @(posedge clk);
    #1 check("R7 irq not yet high on set edge", 32'(irq_out), 32'h0);
    @(negedge clk); evt_pulse = '0;
    @(posedge clk);
    #1 check("R7 irq0 one cycle later, irq1 idle", 32'(irq_out), 32'h1);
    @(negedge clk); live_state = 11'h002;
    @(posedge clk);
    #1 check("R7 irq1 from live bit 12", 32'(irq_out), 32'h3);
    bus_write(12'h038, 32'h80);
    @(posedge clk);
    #1 check("R7 irq0 drops after clear", 32'(irq_out), 32'h2);
    @(negedge clk); live_state = '0;
    bus_write(12'h03C, 32'h0);
    bus_write(12'h040, 32'h0);
    @(posedge clk);
    #1 check("R7 both lines low", 32'(irq_out), 32'h0);
  endtask

  task automatic t_id();
    logic [31:0] r;
    for (int n = 0; n < 8; n++) begin
      bus_read(12'hFE0 + 12'(4 * n), r);
      check("R8 id byte", r, 32'(expect_id(n)));
    end
  endtask

  task automatic t_other();
    logic [31:0] r;
    bus_write(12'h03C, 32'h55);
    bus_write(12'h044, 32'hFFFF_FFFF);
    bus_write(12'h000, 32'hFFFF_FFFF);
    bus_read(12'h03C, r); check("R9 stray write leaves mask0", r, 32'h55);
    bus_read(12'h040, r); check("R9 stray write leaves mask1", r, 32'h0);
    pulse(11'h003);
    bus_write(12'h034, 32'h7FF);
    bus_read(12'h034, r); check("R9 write to status offset ignored", r, 32'h3);
    bus_read(12'h038, r); check("R9 clear offset reads zero", r, 32'h0);
    bus_read(12'h000, r); check("R9 unmapped offset reads zero", r, 32'h0);
    bus_write(12'h03C, 32'h0);
    bus_write(12'h038, 32'h7FF);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_sticky();
    t_live();
    t_partial();
    t_setwins();
    t_mask();
    t_irq();
    t_id();
    t_other();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule